// File: doc/BRIEF.md
# Exclusive Access Reservation Monitor

This block sits beside the address channels of a small AXI4 memory slave and decides whether exclusive (locked) writes may land in memory. It watches each accepted read address and write address together with its transaction ID and lock bit. It keeps a reservation table with one slot per ID. An exclusive read records the word it targets in the slot for its ID. An exclusive write is allowed through only if its own slot still holds the same word.

Any write that actually lands in memory clears every slot whose word it touches. An ordinary write does this, and so does a passing exclusive write. As a result, when two IDs contend for one word, the first writer succeeds and every stale reservation fails later. The slave's memory array, the channel handshakes and the response muxing stay outside the block. The block supplies the response codes for the read and write channels and a gate on the memory write enable.

Exclusivity applies only to single-beat transfers no wider than the 4-byte data bus and aligned to their own size. An exclusive request of any other shape is answered as if it were ordinary. Such a request never touches the table, and an exclusive write of that shape is kept out of memory.

Top module: `excl_monitor`

## Requirements
- R1: An eligible exclusive read (rdValid and rdLock high) stores its ID's reservation for the addressed 4-byte word and gets rdResp 01 (EXOKAY). Every other read gets rdResp 00 (OKAY) and leaves the table unchanged.
- R2: Eligibility for exclusivity means all three of: length field 0 (one beat), size field at most 2 (4 bytes), and an address that is a multiple of 2^size. An exclusive read that is not eligible gets OKAY and records nothing.
- R3: An eligible exclusive write passes only when its own ID holds a valid reservation for the same 4-byte word. A passing write gets wrResp 01 (EXOKAY) and wrCommit 1.
- R4: An eligible exclusive write that fails the check gets wrResp 00 and wrCommit 0. It leaves other IDs' reservations untouched.
- R5: An exclusive write that is not eligible gets wrResp 00 and wrCommit 0. It leaves the whole table unchanged, including its own ID's slot.
- R6: Once an eligible exclusive write has been checked, the slot of the writing ID is cleared, whether the check passed or failed.
- R7: A write that commits clears every reservation whose word lies inside the bytes it touches. That span runs from the start address for (len+1)<<size bytes.
- R8: The table holds one slot per ID. A new eligible exclusive read from an ID replaces that ID's earlier reservation.
- R9: When a write and an eligible exclusive read arrive in the same cycle, the write's clearing is applied first and the read's new reservation survives.
- R10: An ordinary write (wrLock low) always gets wrCommit 1 and wrResp 00.
- R11: After reset no ID holds a reservation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | A read address is accepted this cycle |
| rdId | input | ID_W | Read transaction ID |
| rdAddr | input | ADDR_W | Read byte address |
| rdLock | input | 1 | Read requests exclusivity |
| rdLen | input | LEN_W | Read beats minus one |
| rdSize | input | 3 | Read bytes per beat, log2 |
| wrValid | input | 1 | A write address is accepted this cycle |
| wrId | input | ID_W | Write transaction ID |
| wrAddr | input | ADDR_W | Write byte address |
| wrLock | input | 1 | Write requests exclusivity |
| wrLen | input | LEN_W | Write beats minus one |
| wrSize | input | 3 | Write bytes per beat, log2 |
| rdResp | output | 2 | Response code for the read (00 OKAY, 01 EXOKAY) |
| wrResp | output | 2 | Response code for the write (00 OKAY, 01 EXOKAY) |
| wrCommit | output | 1 | Gate on the memory write enable for this write |

## Verification
The two functions that can fall in one cycle are the clearing caused by a write and the new reservation from an exclusive read, and this covers both the release of the writer's own slot and the range clearing of a committing write. The bench provokes this directly. It issues an ordinary write and an exclusive read to the same word in one cycle, and also issues an exclusive write and an exclusive read from the same ID in one cycle. It then judges the result through a later exclusive write from the reading ID, which must pass. A random phase mixes both channels every cycle over four words, and a behavioural model holding the reservations as plain integers predicts every response.

// File: rtl/excl_mon_pkg.sv
`timescale 1ns/1ps
package excl_mon_pkg;

  localparam logic [1:0] RESP_OKAY   = 2'b00;
  localparam logic [1:0] RESP_EXOKAY = 2'b01;

  // Strobes from control to the reservation table
  typedef struct packed {
    logic setRes;      // record the read's reservation
    logic releaseOwn;  // drop the writing ID's slot
    logic invalidate;  // clear every slot the write touches
  } tbl_strb_t;

endpackage

// File: rtl/excl_mon_elig.sv
`timescale 1ns/1ps
module excl_mon_elig #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [LEN_W-1:0]  len,
  input  logic [2:0]        size,
  output logic              eligible
);
  localparam int WORD_LSB = $clog2(DATA_BYTES);

  logic [ADDR_W-1:0] alignMask;
  logic singleBeat, sizeFits, aligned;

  always_comb begin
    alignMask  = (ADDR_W'(1) << size) - ADDR_W'(1);
    singleBeat = (len == '0);
    sizeFits   = (size <= 3'(WORD_LSB));
    aligned    = ((addr & alignMask) == '0);
    eligible   = singleBeat && sizeFits && aligned;
  end
endmodule

// File: rtl/excl_mon_ctrl.sv
`timescale 1ns/1ps
module excl_mon_ctrl
  import excl_mon_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic              rdValid,
  input  logic              rdLock,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [LEN_W-1:0]  rdLen,
  input  logic [2:0]        rdSize,
  input  logic              wrValid,
  input  logic              wrLock,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic [2:0]        wrSize,
  input  logic              ownMatch,
  output tbl_strb_t         strb,
  output logic [1:0]        rdResp,
  output logic [1:0]        wrResp,
  output logic              wrCommit
);
  logic rdElig, wrElig;
  logic rdExcl, wrExcl, wrPass;

  excl_mon_elig #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) rdEligInst (
    .addr(rdAddr), .len(rdLen), .size(rdSize), .eligible(rdElig)
  );
  excl_mon_elig #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) wrEligInst (
    .addr(wrAddr), .len(wrLen), .size(wrSize), .eligible(wrElig)
  );

  always_comb begin
    rdExcl   = rdValid && rdLock && rdElig;
    wrExcl   = wrValid && wrLock && wrElig;
    wrPass   = wrExcl && ownMatch;
    // ordinary writes always land; exclusive ones only on a pass
    wrCommit = wrValid && (!wrLock || wrPass);

    strb.setRes     = rdExcl;
    strb.releaseOwn = wrExcl;
    strb.invalidate = wrCommit;

    rdResp = rdExcl ? RESP_EXOKAY : RESP_OKAY;
    wrResp = wrPass ? RESP_EXOKAY : RESP_OKAY;
  end
endmodule

// File: rtl/excl_mon_table.sv
`timescale 1ns/1ps
module excl_mon_table
  import excl_mon_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  tbl_strb_t             strb,
  input  logic [ID_W-1:0]       rdId,
  input  logic [ADDR_W-1:0]     rdAddr,
  input  logic [ID_W-1:0]       wrId,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [LEN_W-1:0]      wrLen,
  input  logic [2:0]            wrSize,
  output logic                  ownMatch,
  output logic [(1<<ID_W)-1:0]  resValidVec
);
  localparam int NUM_IDS  = 1 << ID_W;
  localparam int WORD_LSB = $clog2(DATA_BYTES);
  localparam int WORD_W   = ADDR_W - WORD_LSB;
  localparam int EXT_W    = ADDR_W + 1;

  logic [WORD_W-1:0]   resWord [NUM_IDS];
  logic [EXT_W-1:0]    spanBytes, endByte;
  logic [WORD_W:0]     startWordExt, endWordExt;
  logic [WORD_W-1:0]   rdWord, wrWord;
  logic [NUM_IDS-1:0]  entryHit;

  // Byte range touched by the write, in words
  always_comb begin
    spanBytes    = EXT_W'({1'b0, wrLen} + (LEN_W+1)'(1)) << wrSize;
    endByte      = {1'b0, wrAddr} + spanBytes - EXT_W'(1);
    startWordExt = {1'b0, wrAddr[ADDR_W-1:WORD_LSB]};
    endWordExt   = endByte[EXT_W-1:WORD_LSB];
    rdWord       = rdAddr[ADDR_W-1:WORD_LSB];
    wrWord       = wrAddr[ADDR_W-1:WORD_LSB];
    ownMatch     = resValidVec[wrId] && (resWord[wrId] == wrWord);
  end

  for (genvar i = 0; i < NUM_IDS; i++) begin : g_entry
    logic clrEntry, setEntry;

    always_comb begin
      entryHit[i] = resValidVec[i] &&
                    ({1'b0, resWord[i]} >= startWordExt) &&
                    ({1'b0, resWord[i]} <= endWordExt);
      clrEntry = (strb.invalidate && entryHit[i]) ||
                 (strb.releaseOwn && (wrId == ID_W'(i)));
      setEntry = strb.setRes && (rdId == ID_W'(i));
    end

    // set is applied after clear: a same-cycle reservation survives
    always_ff @(posedge clk) begin
      if (!rstN) begin
        resValidVec[i] <= 1'b0;
        resWord[i]     <= '0;
      end else if (setEntry) begin
        resValidVec[i] <= 1'b1;
        resWord[i]     <= rdWord;
      end else if (clrEntry) begin
        resValidVec[i] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/excl_monitor.sv
`timescale 1ns/1ps
module excl_monitor
  import excl_mon_pkg::*;
#(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ID_W-1:0]   rdId,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic              rdLock,
  input  logic [LEN_W-1:0]  rdLen,
  input  logic [2:0]        rdSize,
  input  logic              wrValid,
  input  logic [ID_W-1:0]   wrId,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic              wrLock,
  input  logic [LEN_W-1:0]  wrLen,
  input  logic [2:0]        wrSize,
  output logic [1:0]        rdResp,
  output logic [1:0]        wrResp,
  output logic              wrCommit
);
  localparam int NUM_IDS = 1 << ID_W;

  tbl_strb_t           strb;
  logic                ownMatch;
  logic [NUM_IDS-1:0]  resValidVec;

  excl_mon_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) ctrlInst (
    .rdValid(rdValid), .rdLock(rdLock), .rdAddr(rdAddr), .rdLen(rdLen), .rdSize(rdSize),
    .wrValid(wrValid), .wrLock(wrLock), .wrAddr(wrAddr), .wrLen(wrLen), .wrSize(wrSize),
    .ownMatch(ownMatch), .strb(strb),
    .rdResp(rdResp), .wrResp(wrResp), .wrCommit(wrCommit)
  );

  excl_mon_table #(.ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)) tableInst (
    .clk(clk), .rstN(rstN), .strb(strb),
    .rdId(rdId), .rdAddr(rdAddr),
    .wrId(wrId), .wrAddr(wrAddr), .wrLen(wrLen), .wrSize(wrSize),
    .ownMatch(ownMatch), .resValidVec(resValidVec)
  );
endmodule

// File: rtl/excl_monitor_chk.sv
`timescale 1ns/1ps
module excl_monitor_chk #(
  parameter int ID_W       = 2,
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 8,
  parameter int DATA_BYTES = 4
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  rdValid,
  input logic [ID_W-1:0]       rdId,
  input logic [ADDR_W-1:0]     rdAddr,
  input logic                  rdLock,
  input logic [LEN_W-1:0]      rdLen,
  input logic [2:0]            rdSize,
  input logic                  wrValid,
  input logic [ID_W-1:0]       wrId,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic                  wrLock,
  input logic [LEN_W-1:0]      wrLen,
  input logic [2:0]            wrSize,
  input logic [1:0]            rdResp,
  input logic [1:0]            wrResp,
  input logic                  wrCommit,
  input logic [(1<<ID_W)-1:0]  resValidVec
);
  localparam int WORD_LSB = $clog2(DATA_BYTES);

  logic [ID_W-1:0] lastRdId, lastWrId;
  logic rdFullWord, wrFullWord;

  always_ff @(posedge clk) begin
    lastRdId <= rdId;
    lastWrId <= wrId;
  end

  always_comb begin
    rdFullWord = (rdLen == '0) && (rdSize == 3'(WORD_LSB)) && (rdAddr[WORD_LSB-1:0] == '0);
    wrFullWord = (wrLen == '0) && (wrSize == 3'(WORD_LSB)) && (wrAddr[WORD_LSB-1:0] == '0);
  end

  assert_reset_clear_R11: assert property (@(posedge clk)
    !rstN |=> (resValidVec == '0));

  assert_read_records_R1: assert property (@(posedge clk) disable iff (!rstN)
    (rdValid && rdLock && rdFullWord) |=> resValidVec[lastRdId]);

  assert_exokay_needs_lock_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wrResp == 2'b01) |-> (wrValid && wrLock && wrCommit));

  assert_fail_blocks_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrLock && wrResp == 2'b00) |-> !wrCommit);

  assert_burst_excl_blocked_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrLock && wrLen != '0) |-> (!wrCommit && wrResp == 2'b00));

  assert_release_own_R6: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && wrLock && wrFullWord && !(rdValid && rdLock && rdId == wrId))
      |=> !resValidVec[lastWrId]);

  assert_plain_write_lands_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wrValid && !wrLock) |-> (wrCommit && wrResp == 2'b00));

  assert_plain_read_okay_R1: assert property (@(posedge clk) disable iff (!rstN)
    !(rdValid && rdLock) |-> (rdResp == 2'b00));
endmodule

bind excl_monitor excl_monitor_chk #(
  .ID_W(ID_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_BYTES(DATA_BYTES)
) chkInst (
  .clk(clk), .rstN(rstN),
  .rdValid(rdValid), .rdId(rdId), .rdAddr(rdAddr), .rdLock(rdLock), .rdLen(rdLen), .rdSize(rdSize),
  .wrValid(wrValid), .wrId(wrId), .wrAddr(wrAddr), .wrLock(wrLock), .wrLen(wrLen), .wrSize(wrSize),
  .rdResp(rdResp), .wrResp(wrResp), .wrCommit(wrCommit),
  .resValidVec(resValidVec)
);

// File: tb/excl_monitor_test.sv
`timescale 1ns/1ps
module excl_monitor_test;
  localparam int PERIOD = 10;
  localparam int ID_W   = 2;
  localparam int ADDR_W = 32;
  localparam int LEN_W  = 8;

  logic clk = 1'b0;
  logic rstN;
  logic rdValid, rdLock, wrValid, wrLock;
  logic [ID_W-1:0] rdId, wrId;
  logic [ADDR_W-1:0] rdAddr, wrAddr;
  logic [LEN_W-1:0] rdLen, wrLen;
  logic [2:0] rdSize, wrSize;
  logic [1:0] rdResp, wrResp;
  logic wrCommit;

  int checks = 0;
  int errors = 0;

  // behavioural reference: one reservation per ID
  bit     mValid [4];
  longint mWord  [4];

  excl_monitor uut (
    .clk(clk), .rstN(rstN),
    .rdValid(rdValid), .rdId(rdId), .rdAddr(rdAddr), .rdLock(rdLock), .rdLen(rdLen), .rdSize(rdSize),
    .wrValid(wrValid), .wrId(wrId), .wrAddr(wrAddr), .wrLock(wrLock), .wrLen(wrLen), .wrSize(wrSize),
    .rdResp(rdResp), .wrResp(wrResp), .wrCommit(wrCommit)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic bit okShape(longint a, int len, int sz);
    return (len == 0) && (sz <= 2) && ((a % (64'd1 << sz)) == 0);
  endfunction

  // one cycle: drive at negedge, check just before posedge, advance the model
  task automatic step(string req,
                      bit rv, int rid, longint ra, bit rl, int rlen, int rsz,
                      bit wv, int wid, longint wa, bit wl, int wlen, int wsz);
    bit rdEx, wrEx, pass, commit;
    longint sW, eW;
    @(negedge clk);
    rdValid = rv; rdId = ID_W'(rid); rdAddr = ADDR_W'(ra); rdLock = rl;
    rdLen = LEN_W'(rlen); rdSize = 3'(rsz);
    wrValid = wv; wrId = ID_W'(wid); wrAddr = ADDR_W'(wa); wrLock = wl;
    wrLen = LEN_W'(wlen); wrSize = 3'(wsz);
    #(PERIOD/2 - 1);
    rdEx   = rv && rl && okShape(ra, rlen, rsz);
    wrEx   = wv && wl && okShape(wa, wlen, wsz);
    pass   = wrEx && mValid[wid] && (mWord[wid] == (wa >> 2));
    commit = wv && (!wl || pass);
    check(req, "rdResp",   int'(rdResp),   rdEx ? 1 : 0);
    check(req, "wrResp",   int'(wrResp),   pass ? 1 : 0);
    check(req, "wrCommit", int'(wrCommit), commit ? 1 : 0);
    sW = wa >> 2;
    eW = (wa + ((longint'(wlen) + 1) << wsz) - 1) >> 2;
    for (int i = 0; i < 4; i++) begin
      if (commit && mValid[i] && mWord[i] >= sW && mWord[i] <= eW) mValid[i] = 0;
    end
    if (wrEx) mValid[wid] = 0;
    if (rdEx) begin
      mValid[rid] = 1;
      mWord[rid]  = ra >> 2;
    end
  endtask

  task automatic idle(string req);
    step(req, 0,0,0,0,0,2, 0,0,0,0,0,2);
  endtask
  task automatic xrd(string req, int id, longint a);
    step(req, 1,id,a,1,0,2, 0,0,0,0,0,2);
  endtask
  task automatic xwr(string req, int id, longint a);
    step(req, 0,0,0,0,0,2, 1,id,a,1,0,2);
  endtask
  task automatic nwr(string req, int id, longint a, int len, int sz);
    step(req, 0,0,0,0,0,2, 1,id,a,0,len,sz);
  endtask

  initial begin
    #(PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mValid[i] = 0; mWord[i] = 0; end
    rstN = 1'b0;
    rdValid = 0; rdId = 0; rdAddr = 0; rdLock = 0; rdLen = 0; rdSize = 2;
    wrValid = 0; wrId = 0; wrAddr = 0; wrLock = 0; wrLen = 0; wrSize = 2;
    repeat (3) @(posedge clk);
    #(PERIOD/2 - 1);
    check("R11", "wrCommit in reset", int'(wrCommit), 0);
    check("R11", "rdResp in reset", int'(rdResp), 0);
    @(negedge clk); rstN = 1'b1;

    // R11: nothing reserved after reset
    xwr("R11", 0, 'h100);
    // R1, R3: basic reserve and pass
    xrd("R1", 1, 'h100);
    xwr("R3", 1, 'h100);
    // R6: second try after release fails
    xwr("R6", 1, 'h100);
    // R6: failing check also releases
    xrd("R6", 2, 'h140);
    xwr("R6", 2, 'h144);
    xwr("R6", 2, 'h140);
    // R7: two IDs on one word, first writer wins
    xrd("R7", 0, 'h200);
    xrd("R7", 2, 'h200);
    xwr("R7", 2, 'h200);
    xwr("R7", 0, 'h200);
    // R7: byte write inside the word clears it
    xrd("R7", 3, 'h304);
    nwr("R10", 1, 'h306, 0, 0);
    xwr("R7", 3, 'h304);
    // R7: burst write clears its whole span only
    xrd("R7", 3, 'h80C);
    xrd("R7", 2, 'h810);
    nwr("R7", 0, 'h800, 3, 2);
    xwr("R7", 3, 'h80C);
    xwr("R7", 2, 'h810);
    // R2: burst and misaligned exclusive reads record nothing
    step("R2", 1,1,'h900,1,1,2, 0,0,0,0,0,2);
    xwr("R2", 1, 'h900);
    step("R2", 1,1,'h902,1,0,2, 0,0,0,0,0,2);
    xwr("R2", 1, 'h900);
    step("R2", 1,1,'h900,1,0,3, 0,0,0,0,0,2);
    // R5: ineligible exclusive write blocked, own slot kept
    xrd("R5", 0, 'hA00);
    step("R5", 0,0,0,0,0,2, 1,0,'hA00,1,1,2);
    step("R5", 0,0,0,0,0,2, 1,0,'hA02,1,0,2);
    xwr("R5", 0, 'hA00);
    // R4: failing write leaves other reservations
    xrd("R4", 0, 'hB00);
    xrd("R4", 1, 'hB00);
    xwr("R4", 2, 'hB00);
    xwr("R4", 0, 'hB00);
    xwr("R4", 1, 'hB00);
    // R8: newer reservation replaces older
    xrd("R8", 1, 'hC00);
    xrd("R8", 1, 'hC40);
    xwr("R8", 1, 'hC00);
    xrd("R8", 1, 'hC00);
    xrd("R8", 1, 'hC40);
    xwr("R8", 1, 'hC40);
    // R9: same-cycle write and reservation to same word
    step("R9", 1,0,'hD00,1,0,2, 1,3,'hD00,0,0,2);
    xwr("R9", 0, 'hD00);
    // R9: same ID releases and re-reserves in one cycle
    xrd("R9", 2, 'hD40);
    step("R9", 1,2,'hD80,1,0,2, 1,2,'hD40,1,0,2);
    xwr("R9", 2, 'hD80);
    // R10: plain writes always land
    nwr("R10", 3, 'hE00, 0, 2);
    nwr("R10", 2, 'hE01, 2, 1);
    idle("R1");

    // mixed random traffic over four words
    for (int n = 0; n < 600; n++) begin
      longint ra, wa;
      int rl, wl, rs, ws;
      ra = longint'($urandom_range(0, 3) * 4) + (($urandom_range(0, 7) == 0) ? 2 : 0);
      wa = longint'($urandom_range(0, 3) * 4) + (($urandom_range(0, 7) == 0) ? 1 : 0);
      rl = ($urandom_range(0, 9) == 0) ? 1 : 0;
      wl = ($urandom_range(0, 7) == 0) ? int'($urandom_range(1, 3)) : 0;
      rs = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 3)) : 2;
      ws = ($urandom_range(0, 7) == 0) ? int'($urandom_range(0, 3)) : 2;
      step("RND", bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), ra, bit'($urandom_range(0, 1)), rl, rs,
                  bit'($urandom_range(0, 1)), int'($urandom_range(0, 3)), wa, bit'($urandom_range(0, 2) != 0), wl, ws);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule